// File: doc/BRIEF.md
# Clock-Stop and Peripheral-Reset Control Register File

This block holds the clock-stop and reset state for up to 64 peripherals and presents it to software through a small synchronous register bus. The state is split into two groups of 64 bits: reset lines and clock-stop bits. Each group is spread across 32-bit registers. Software never needs a read-modify-write. Each register has a set address and a companion clear address 4 bytes above it. Writing ones to the set address raises the matching bits. Writing ones to the clear address drops them. Zero bits in the write data never change anything.

The block drives one reset level and one clock-enable level per peripheral. The enable takes the per-bit polarity into account. For every line, a stored one means "clock stopped", with one exception: on line 14 a stored one means "clock running". One stop bit has a second use. Bit 31 of the first clock register also selects a divide-by-13 reference for a group of UART clocks, and that bit is brought out on a separate pin.

Read data is registered and appears one cycle after the address. A read in the same cycle as a write to the same register returns the value from before the write.

Top module: `clkrst_ctrl_regs`

## Requirements
- R1: After reset, every reset line is asserted. Every clock-stop bit holds one, except bit 14, which holds zero. As a result every clock enable is low and the divide-by-13 select is high.
- R2: A write to a set address ORs the write data into that register. Bits written as zero keep their value.
- R3: A write to a clear address (set address + 0x4) clears every bit written as one. Bits written as zero keep their value.
- R4: Line index i lives in bit i mod 32. Lines 0-31 use the first register of a group and lines 32-63 use the second. The reset registers sit at 0x040 and 0x050, and the clock-stop registers at 0x080 and 0x090.
- R5: The clock enable of line i is the inverse of its stop bit for every line except line 14. For line 14 the enable equals the stored bit.
- R6: The reset output of each line equals its stored reset bit (1 = held in reset).
- R7: The divide-by-13 select output equals clock-stop bit 31 of the register at 0x080.
- R8: A read of either the set address or the clear address of a register returns that register's current contents on bus_rdata one clock after the address is presented.
- R9: A read of any other offset returns zero, and a write to any other offset changes no state.
- R10: A read and a write to the same register in one cycle return the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data; ones select bits to set or clear |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| clk_en | output | 64 | Per-line clock enable, polarity applied |
| periph_rst | output | 64 | Per-line reset, high holds the peripheral in reset |
| uart_div13_sel | output | 1 | Divide-by-13 select for the UART reference group |

## Verification
The assertions assume that the decoder never issues a set strobe and a clear strobe to the same register in one cycle. They also assume that bus_addr and bus_we are stable across each clock edge. The bench drives all inputs on the falling edge and issues at most one access per cycle, so both assumptions hold. Addresses include every set and clear offset, unmapped offsets both inside and outside the decoded window, and write data with all-zero, single-bit and mixed patterns.

// File: rtl/clkrst_pkg.sv
package clkrst_pkg;

    // Which half of the register file a register belongs to.
    typedef enum logic {
        GRP_RESET = 1'b0,
        GRP_CLOCK = 1'b1
    } grp_e;

    // Base byte offset of register r inside group g.
    function automatic int reg_base(input int grp_base, input int stride, input int r);
        return grp_base + r * stride;
    endfunction

endpackage

// File: rtl/clkrst_decode.sv
module clkrst_decode #(
    parameter int ADDR_W   = 12,
    parameter int RPG      = 2,        // registers per group
    parameter int RST_BASE = 'h040,
    parameter int CLK_BASE = 'h080,
    parameter int STRIDE   = 'h010,
    parameter int CLR_OFS  = 'h004,
    localparam int NREG    = 2 * RPG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output logic [NREG-1:0]   set_stb,
    output logic [NREG-1:0]   clr_stb,
    output logic [NREG-1:0]   rd_hit
);
    import clkrst_pkg::*;

    for (genvar g = 0; g < 2; g++) begin : g_grp
        localparam grp_e GRP = grp_e'(g);
        localparam int GBASE = (GRP == GRP_RESET) ? RST_BASE : CLK_BASE;
        for (genvar r = 0; r < RPG; r++) begin : g_reg
            localparam int K      = g * RPG + r;
            localparam int SET_I  = reg_base(GBASE, STRIDE, r);
            localparam int CLR_I  = SET_I + CLR_OFS;
            localparam logic [ADDR_W-1:0] SET_A = SET_I[ADDR_W-1:0];
            localparam logic [ADDR_W-1:0] CLR_A = CLR_I[ADDR_W-1:0];
            logic at_set, at_clr;
            always_comb begin
                at_set     = (addr == SET_A);
                at_clr     = (addr == CLR_A);
                set_stb[K] = we && at_set;
                clr_stb[K] = we && at_clr;
                rd_hit[K]  = at_set || at_clr;
            end
        end
    end

    // R4
    // one_strobe_chk
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_stb, clr_stb}));

endmodule

// File: rtl/clkrst_bank.sv
module clkrst_bank #(
    parameter int W = 32,
    parameter logic [W-1:0] RESET_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic [W-1:0] set_mask, clr_mask;

    always_comb begin
        set_mask = set_stb ? wdata : '0;
        clr_mask = clr_stb ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= (q | set_mask) & ~clr_mask;
    end

    // R2
    // set_bits_chk
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> ((q & $past(wdata)) == $past(wdata)));

    // R3
    // clr_bits_chk
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((q & $past(wdata)) == '0));

    // R9
    // hold_chk
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stb && !clr_stb) |=> $stable(q));

endmodule

// File: rtl/clkrst_rdmux.sv
module clkrst_rdmux #(
    parameter int W    = 32,
    parameter int NREG = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NREG-1:0]     rd_hit,
    input  logic [NREG*W-1:0]   words,
    output logic [W-1:0]        rdata
);
    logic [W-1:0] sel;

    always_comb begin
        sel = '0;
        for (int k = 0; k < NREG; k++)
            if (rd_hit[k]) sel = sel | words[k*W +: W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= sel;
    end

    // R9
    // unmapped_zero_chk
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_hit) == '0) |-> (rdata == '0));

endmodule

// File: rtl/clkrst_ctrl_regs.sv
module clkrst_ctrl_regs #(
    parameter int ADDR_W    = 12,
    parameter int REG_W     = 32,
    parameter int LINES     = 64,
    parameter int RST_BASE  = 'h040,
    parameter int CLK_BASE  = 'h080,
    parameter int STRIDE    = 'h010,
    parameter int CLR_OFS   = 'h004,
    parameter int INV_LINE  = 14,
    parameter int DIV13_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [LINES-1:0]  clk_en,
    output logic [LINES-1:0]  periph_rst,
    output logic              uart_div13_sel
);
    localparam int RPG  = LINES / REG_W;
    localparam int NREG = 2 * RPG;

    logic [NREG-1:0]       set_stb, clr_stb, rd_hit;
    logic [NREG*REG_W-1:0] words;
    logic [LINES-1:0]      stop_bits;

    clkrst_decode #(
        .ADDR_W(ADDR_W), .RPG(RPG), .RST_BASE(RST_BASE), .CLK_BASE(CLK_BASE),
        .STRIDE(STRIDE), .CLR_OFS(CLR_OFS)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
        .set_stb(set_stb), .clr_stb(clr_stb), .rd_hit(rd_hit)
    );

    for (genvar k = 0; k < NREG; k++) begin : g_bank
        localparam bit IS_CLK  = (k >= RPG);
        localparam int R       = k % RPG;
        localparam bit HAS_INV = IS_CLK && (INV_LINE / REG_W == R);
        localparam logic [REG_W-1:0] INV_MASK =
            HAS_INV ? (REG_W'(1) << (INV_LINE % REG_W)) : '0;
        clkrst_bank #(.W(REG_W), .RESET_VAL(~INV_MASK)) u_bank (
            .clk(clk), .rst_n(rst_n), .set_stb(set_stb[k]), .clr_stb(clr_stb[k]),
            .wdata(bus_wdata), .q(words[k*REG_W +: REG_W])
        );
    end

    clkrst_rdmux #(.W(REG_W), .NREG(NREG)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .words(words), .rdata(bus_rdata)
    );

    assign periph_rst = words[LINES-1:0];
    assign stop_bits  = words[2*LINES-1:LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_pol
        if (i == INV_LINE) begin : g_hi
            assign clk_en[i] = stop_bits[i];
        end else begin : g_lo
            assign clk_en[i] = ~stop_bits[i];
        end
    end

    assign uart_div13_sel = stop_bits[DIV13_BIT];

endmodule

// File: tb/tb_clkrst_ctrl_regs.sv
module tb_clkrst_ctrl_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] clk_en, periph_rst;
    logic        uart_div13_sel;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkrst_ctrl_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_en(clk_en),
        .periph_rst(periph_rst), .uart_div13_sel(uart_div13_sel)
    );

    // Reference state built from the requirements
    logic [63:0] m_rst, m_stop;

    typedef struct {
        logic [31:0] rd;
        logic [63:0] en;
        logic [63:0] rs;
        logic        dv;
        string       tag;
    } exp_t;
    exp_t sb[$];

    function automatic logic [31:0] m_read(input logic [11:0] a);
        case (a)
            12'h040, 12'h044: return m_rst[31:0];
            12'h050, 12'h054: return m_rst[63:32];
            12'h080, 12'h084: return m_stop[31:0];
            12'h090, 12'h094: return m_stop[63:32];
            default:          return 32'h0;
        endcase
    endfunction

    function automatic logic [63:0] m_en();
        logic [63:0] e;
        for (int i = 0; i < 64; i++) e[i] = (i == 14) ? m_stop[i] : ~m_stop[i];
        return e;
    endfunction

    task automatic m_write(input logic [11:0] a, input logic [31:0] d);
        case (a)
            12'h040: m_rst[31:0]   = m_rst[31:0]   | d;
            12'h044: m_rst[31:0]   = m_rst[31:0]   & ~d;
            12'h050: m_rst[63:32]  = m_rst[63:32]  | d;
            12'h054: m_rst[63:32]  = m_rst[63:32]  & ~d;
            12'h080: m_stop[31:0]  = m_stop[31:0]  | d;
            12'h084: m_stop[31:0]  = m_stop[31:0]  & ~d;
            12'h090: m_stop[63:32] = m_stop[63:32] | d;
            12'h094: m_stop[63:32] = m_stop[63:32] & ~d;
            default: ;
        endcase
    endtask

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: one bus cycle, expected results pushed to the scoreboard
    task automatic op(input logic [11:0] a, input logic w, input logic [31:0] d,
                      input string tag);
        exp_t e;
        @(negedge clk);
        bus_addr  = a;
        bus_we    = w;
        bus_wdata = d;
        e.rd  = m_read(a);          // R10: old contents on a same-cycle write
        if (w) m_write(a, d);
        e.en  = m_en();
        e.rs  = m_rst;
        e.dv  = m_stop[31];
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compares one cycle after the access
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, "rdata", 64'(bus_rdata), 64'(e.rd));
            check(e.tag, "clk_en", clk_en, e.en);
            check(e.tag, "periph_rst", periph_rst, e.rs);
            check(e.tag, "div13", 64'(uart_div13_sel), 64'(e.dv));
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] pat;
        m_rst  = '1;
        m_stop = ~(64'h1 << 14);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state at the ports
        check("R1", "clk_en", clk_en, 64'h0);
        check("R1", "periph_rst", periph_rst, '1);
        check("R1", "div13", 64'(uart_div13_sel), 64'h1);

        // R8 / R1: read back every register at both addresses
        op(12'h040, 0, 0, "R8"); op(12'h044, 0, 0, "R8");
        op(12'h050, 0, 0, "R8"); op(12'h054, 0, 0, "R8");
        op(12'h080, 0, 0, "R1"); op(12'h084, 0, 0, "R8");
        op(12'h090, 0, 0, "R8"); op(12'h094, 0, 0, "R8");

        // R5: line 14 enabled by setting its bit; line 0 by clearing
        op(12'h080, 1, 32'h0000_4000, "R5");
        op(12'h084, 1, 32'h0000_0001, "R5");
        op(12'h080, 0, 0, "R5");
        // R7: divide-by-13 select follows bit 31
        op(12'h084, 1, 32'h8000_0000, "R7");
        op(12'h080, 1, 32'h8000_0000, "R7");
        // R4 / R6: line 32 and line 63 reset release, line 1 too
        op(12'h054, 1, 32'h8000_0001, "R4");
        op(12'h044, 1, 32'h0000_0002, "R6");
        op(12'h050, 0, 0, "R4");
        // R4: clock lines 40 and 45 in the second clock register
        op(12'h094, 1, 32'h0000_2100, "R4");
        // R2: zero write data leaves state unchanged
        op(12'h040, 1, 32'h0, "R2");
        op(12'h054, 1, 32'h0, "R3");
        op(12'h044, 1, 32'hFFFF_0000, "R3");
        op(12'h040, 1, 32'h0001_0000, "R2");
        // R9: unmapped offsets
        op(12'h060, 1, 32'hFFFF_FFFF, "R9");
        op(12'h048, 1, 32'hFFFF_FFFF, "R9");
        op(12'h0C0, 1, 32'hFFFF_FFFF, "R9");
        op(12'h060, 0, 0, "R9");
        op(12'hFFC, 0, 0, "R9");
        // R10: back-to-back writes then read of the same register
        op(12'h090, 1, 32'hA5A5_A5A5, "R10");
        op(12'h094, 1, 32'hFFFF_0000, "R10");
        op(12'h090, 0, 0, "R10");
        // Mixed patterns across every register
        pat = 32'h1357_9BDF;
        for (int i = 0; i < 32; i++) begin
            logic [11:0] a;
            pat = {pat[30:0], pat[31] ^ pat[21] ^ pat[1] ^ pat[0]};
            case (i % 8)
                0: a = 12'h040; 1: a = 12'h044; 2: a = 12'h050; 3: a = 12'h054;
                4: a = 12'h080; 5: a = 12'h084; 6: a = 12'h090; default: a = 12'h094;
            endcase
            op(a, 1, pat, (i % 2 == 0) ? "R2" : "R3");
        end
        op(12'h080, 0, 0, "R8");
        @(negedge clk);
        bus_we = 0;
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule